// File: doc/BRIEF.md
# Nonvolatile Command Status and Launch Gate

This block holds the status byte that software uses to start and watch commands on a nonvolatile memory command engine. A byte-wide register port writes the status byte, and its read data always shows the current flags. Three error flags record problems: an access fault reported by the engine, a protection fault reported by the engine, and a collision caused by software writing while a command runs. One execution-error status bit reports how the last command ended.

A command starts when software writes 1 to the idle flag. The launch happens only while the idle flag is set and no error flag is pending. The block then sends a one-cycle launch pulse to the engine and drops the idle flag. When the engine sends its done pulse, the idle flag is set again and the execution-error status is loaded. Software clears error flags by writing 1 to them, and only while the engine is idle.

Top module: `fcg_status_gate`

## Requirements
- R1: After reset, `reg_rdata` reads 0x80 (idle flag set, all other bits 0) and `cmd_launch` is 0.
- R2: A write with bit 7 = 1, made while bit 7 reads 1 and bits 6:4 read 0, drives `cmd_launch` high in that cycle. From the next cycle, bit 7 and bit 0 read 0.
- R3: While any of bits 6, 5 or 4 reads 1, writing 1 to bit 7 gives no launch pulse and bit 7 stays 1. The check uses the flags as they read before the write.
- R4: Bits 6, 5 and 4 are write-1-to-clear, and a clear takes effect only while bit 7 reads 1. Writing 0 to them changes nothing. Writing 1 to them while bit 7 reads 0 changes nothing.
- R5: A pulse on `eng_acc_err` sets bit 5, and a pulse on `eng_prot_err` sets bit 4. Setting wins over a clear written in the same cycle.
- R6: Any register write while bit 7 reads 0 sets the collision flag, bit 6. Such a write clears no flag and launches nothing.
- R7: An `eng_done` pulse while bit 7 reads 0 sets bit 7 on the next cycle and loads `eng_exec_err` into bit 0.
- R8: Writes cannot change bit 0. Bit 0 is cleared on the clock edge of a launch. A pulse on `boot_err` sets bit 0, and it wins over a launch in the same cycle.
- R9: Bits 3:1 always read 0 and ignore writes.
- R10: `cmd_launch` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Status byte write strobe |
| reg_wdata | input | 8 | Status byte write data |
| reg_rdata | output | 8 | Current status byte |
| eng_acc_err | input | 1 | Engine pulse: illegal command or sequence fault |
| eng_prot_err | input | 1 | Engine pulse: protected region targeted |
| eng_done | input | 1 | Engine pulse: command finished |
| eng_exec_err | input | 1 | Execution error, qualified by `eng_done` |
| boot_err | input | 1 | Pulse: error found during the reset sequence |
| cmd_launch | output | 1 | One-cycle command start toward the engine |
| cmd_idle | output | 1 | Copy of the idle flag (bit 7) |

## Verification
The assertions assume the engine sends `eng_done` only while a command is in flight, that is, while bit 7 reads 0. A done pulse that arrives while idle is ignored, and no property depends on it. The stimulus raises `eng_done` only after a launch and before the next one. It keeps `boot_err` low during launch and clear cases, so those properties see clean conditions. Writes during execution are issued on purpose to exercise the collision path.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned ERR_N   = 3;
  localparam int unsigned ERR_LSB = 4;
  localparam int unsigned B_IDLE  = 7;
  localparam int unsigned B_COL   = 6;
  localparam int unsigned B_ACC   = 5;
  localparam int unsigned B_PROT  = 4;
  localparam int unsigned B_EXEC  = 0;
endpackage

// File: rtl/fcg_err_flag.sv
module fcg_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;
  logic flag_en;

  assign flag_en = set_i | clr_i;

  // set has priority over a clear in the same cycle
  always_comb begin
    flag_d = flag_o;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_o <= 1'b0;
    else if (flag_en) flag_o <= flag_d;
  end
endmodule

// File: rtl/fcg_cmd_ctrl.sv
module fcg_cmd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wr_go_i,
  input  logic err_any_i,
  input  logic done_i,
  input  logic exec_err_i,
  input  logic boot_err_i,
  output logic idle_o,
  output logic exec_o,
  output logic launch_o
);
  logic idle_d, exec_d;
  logic idle_en, exec_en;
  logic finish;

  assign launch_o = wr_i & wr_go_i & idle_o & ~err_any_i;
  assign finish   = done_i & ~idle_o;

  always_comb begin
    idle_d = idle_o;
    if (launch_o)    idle_d = 1'b0;
    else if (finish) idle_d = 1'b1;
    idle_en = launch_o | finish;
  end

  always_comb begin
    exec_d = exec_o;
    if (launch_o)    exec_d = 1'b0;
    else if (finish) exec_d = exec_err_i;
    if (boot_err_i)  exec_d = 1'b1;
    exec_en = launch_o | finish | boot_err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idle_o <= 1'b1;
    else if (idle_en) idle_o <= idle_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       exec_o <= 1'b0;
    else if (exec_en) exec_o <= exec_d;
  end
endmodule

// File: rtl/fcg_status_gate.sv
module fcg_status_gate
  import fcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             eng_acc_err,
  input  logic             eng_prot_err,
  input  logic             eng_done,
  input  logic             eng_exec_err,
  input  logic             boot_err,
  output logic             cmd_launch,
  output logic             cmd_idle
);
  logic [ERR_N-1:0] err_set, err_clr, err_q;
  logic             idle_q, exec_q;
  logic             clr_ok;

  assign clr_ok  = reg_wr & idle_q;
  assign err_set = {reg_wr & ~idle_q, eng_acc_err, eng_prot_err};
  assign err_clr = {ERR_N{clr_ok}} & reg_wdata[ERR_LSB +: ERR_N];

  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    fcg_err_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (err_set[i]),
      .clr_i  (err_clr[i]),
      .flag_o (err_q[i])
    );
  end

  fcg_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr),
    .wr_go_i    (reg_wdata[B_IDLE]),
    .err_any_i  (|err_q),
    .done_i     (eng_done),
    .exec_err_i (eng_exec_err),
    .boot_err_i (boot_err),
    .idle_o     (idle_q),
    .exec_o     (exec_q),
    .launch_o   (cmd_launch)
  );

  always_comb begin
    reg_rdata                         = '0;
    reg_rdata[B_IDLE]                 = idle_q;
    reg_rdata[ERR_LSB +: ERR_N]       = err_q;
    reg_rdata[B_EXEC]                 = exec_q;
  end

  assign cmd_idle = idle_q;
endmodule

// File: rtl/fcg_status_gate_chk.sv
module fcg_status_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       eng_acc_err,
  input logic       eng_prot_err,
  input logic       eng_done,
  input logic       eng_exec_err,
  input logic       boot_err,
  input logic       cmd_launch,
  input logic       cmd_idle
);
  p_launch_drops_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_launch && !boot_err |=> !reg_rdata[7] && !reg_rdata[0]);
  p_blocked_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_rdata[7] && (|reg_rdata[6:4]) |-> !cmd_launch);
  p_blocked_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_rdata[7] && (|reg_rdata[6:4]) |=> reg_rdata[7]);
  p_clear_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_rdata[7] && reg_wdata[5] && !eng_acc_err |=> !reg_rdata[5]);
  p_set_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_acc_err |=> reg_rdata[5]);
  p_set_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_prot_err |=> reg_rdata[4]);
  p_collision_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !reg_rdata[7] |=> reg_rdata[6]);
  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && !reg_rdata[7] && !reg_wr |=> reg_rdata[7]);
  p_boot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_err |=> reg_rdata[0]);
  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[3:1] == 3'b000);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_launch |=> !cmd_launch);
  p_idle_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_idle == reg_rdata[7]);
endmodule

bind fcg_status_gate fcg_status_gate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .eng_acc_err  (eng_acc_err),
  .eng_prot_err (eng_prot_err),
  .eng_done     (eng_done),
  .eng_exec_err (eng_exec_err),
  .boot_err     (boot_err),
  .cmd_launch   (cmd_launch),
  .cmd_idle     (cmd_idle)
);

// File: tb/fcg_status_gate_test.sv
module fcg_status_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       eng_acc_err = 1'b0, eng_prot_err = 1'b0, eng_done = 1'b0;
  logic       eng_exec_err = 1'b0, boot_err = 1'b0;
  logic       cmd_launch, cmd_idle;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  typedef struct {
    logic       launch;
    logic [7:0] rd;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  fcg_status_gate uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .eng_acc_err(eng_acc_err), .eng_prot_err(eng_prot_err),
    .eng_done(eng_done), .eng_exec_err(eng_exec_err), .boot_err(boot_err),
    .cmd_launch(cmd_launch), .cmd_idle(cmd_idle)
  );

  // driver: one cycle of stimulus plus the expected response
  task automatic step(input logic wr, input logic [7:0] d, input logic acc,
                      input logic prot, input logic dn, input logic xe,
                      input logic bt, input logic e_launch,
                      input logic [7:0] e_rd, input string tag);
    exp_t e;
    @(negedge clk);
    reg_wr = wr; reg_wdata = d; eng_acc_err = acc; eng_prot_err = prot;
    eng_done = dn; eng_exec_err = xe; boot_err = bt;
    e.launch = e_launch; e.rd = e_rd; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: launch before the edge, register state after it
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (cmd_launch !== e.launch) begin
          errors++;
          $display("FAIL %s launch: actual=%b expected=%b", e.tag, cmd_launch, e.launch);
        end
        @(posedge clk);
        #1;
        checks++;
        if (reg_rdata !== e.rd) begin
          errors++;
          $display("FAIL %s status: actual=%h expected=%h", e.tag, reg_rdata, e.rd);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done_run) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (reg_rdata !== 8'h80) begin
      errors++;
      $display("FAIL R1 reset: actual=%h expected=80", reg_rdata);
    end
    //        wr  data  acc prot dn xe bt  launch rd
    step(0, 8'h00, 0, 0, 0, 0, 0, 0, 8'h80, "R1 idle");
    step(1, 8'h00, 0, 0, 0, 0, 0, 0, 8'h80, "R4 write zero");
    step(1, 8'h80, 0, 0, 0, 0, 0, 1, 8'h00, "R2 launch");
    step(0, 8'h00, 0, 0, 0, 0, 0, 0, 8'h00, "R10 single pulse");
    step(0, 8'h00, 0, 0, 1, 1, 0, 0, 8'h81, "R7 done with error");
    step(1, 8'h01, 0, 0, 0, 0, 0, 0, 8'h81, "R8 exec not writable");
    step(1, 8'h8E, 0, 0, 0, 0, 0, 1, 8'h00, "R8 R9 launch clears exec");
    step(1, 8'h70, 0, 0, 0, 0, 0, 0, 8'h40, "R6 write while busy");
    step(0, 8'h00, 0, 0, 1, 0, 0, 0, 8'hC0, "R7 done clean");
    step(1, 8'h80, 0, 0, 0, 0, 0, 0, 8'hC0, "R3 collision blocks");
    step(1, 8'h40, 0, 0, 0, 0, 0, 0, 8'h80, "R4 clear collision");
    step(0, 8'h00, 1, 0, 0, 0, 0, 0, 8'hA0, "R5 access set");
    step(0, 8'h00, 0, 1, 0, 0, 0, 0, 8'hB0, "R5 protection set");
    step(1, 8'h90, 0, 0, 0, 0, 0, 0, 8'hA0, "R3 blocked with clear");
    step(1, 8'h20, 1, 0, 0, 0, 0, 0, 8'hA0, "R5 set beats clear");
    step(1, 8'h20, 0, 0, 0, 0, 0, 0, 8'h80, "R4 clear access");
    step(0, 8'h00, 0, 0, 0, 0, 1, 0, 8'h81, "R8 boot error");
    step(1, 8'h80, 0, 0, 0, 0, 0, 1, 8'h00, "R2 relaunch");
    step(0, 8'h00, 0, 1, 0, 0, 0, 0, 8'h10, "R5 protection while busy");
    step(1, 8'h10, 0, 0, 0, 0, 0, 0, 8'h50, "R4 R6 no clear while busy");
    step(0, 8'h00, 0, 0, 1, 1, 0, 0, 8'hD1, "R7 done error flags");
    step(1, 8'h70, 0, 0, 0, 0, 0, 0, 8'h81, "R4 clear all");
    step(1, 8'h80, 0, 0, 0, 0, 0, 1, 8'h00, "R2 launch again");
    step(0, 8'h00, 0, 0, 1, 0, 0, 0, 8'h80, "R7 final done");
    step(0, 8'h00, 0, 0, 0, 0, 0, 0, 8'h80, "R9 quiet");
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done_run = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule